// File: doc/BRIEF.md
# Bus Memory Zone Write Monitor

A passive checker that watches every transfer on a shared system bus and reports accesses that break memory-zone rules. It never drives, stalls or changes the bus. Any response goes to the processor as an exception request, raised from a latched violation flag. Only transfers that appear on the bus are judged, so the system must run its caches in write-through mode.

The monitor holds three kinds of zone. The first is a read-only range. The second is the application's static-data range, which covers the initialised data and the zero-filled globals as one contiguous span. The third is a table of heap chunks. Software loads the bounds and reports allocation events through a small write-only register port. When an allocation completes, the returned pointer and the requested size become a live chunk. A free turns that chunk into a retired entry. A retired entry keeps its bounds, so that a later touch of the memory can be caught as a use after free, until a new allocation takes over the slot.

The first violation latches. The flag, the offending address and a two-bit cause stay held until software clears them.

Top module: `zone_guard`

## Requirements
- R1: A bus write (read or write is bus_write 0/1) whose address lies in [ro lower bound, ro upper bound] (register offsets 0 and 1) raises a violation with cause 2'b00; a read there raises none.
- R2: A write marked as coming from the monitored application (bus_app=1) raises cause 2'b01 when its byte range addr..addr+2^bus_size-1 does not lie inside the static-data range (offsets 2 and 3), unless its start lies inside a live chunk. Writes with bus_app=0 and application reads are never judged by this rule.
- R3: Writing the pointer to offset 4 and then a non-zero size to offset 5 records the live chunk base..base+size-1. An access that starts inside the chunk and ends beyond it raises cause 2'b10. An access that lies wholly inside the chunk raises nothing.
- R4: Writing a pointer to offset 6 retires the live chunk with that base. Any later read or write starting inside that chunk, with no live chunk covering the address, raises cause 2'b11. A retired entry keeps its bounds until an allocation reuses its slot.
- R5: The table holds 8 chunks. An allocation goes to an empty slot first and to a retired slot second. An allocation with neither available sets table_full and raises no violation. Writing offset 7 with bit 1 set clears table_full.
- R6: The first violation sets viol_flag and captures viol_addr and viol_cause one clock after the transfer. Later violations leave all three unchanged until a write to offset 7 with bit 0 set clears the flag.
- R7: When a clear and a new violation fall in the same cycle, the new violation is captured and the flag stays set.
- R8: When several rules match one transfer, the cause follows the order 2'b00, then 2'b11, then 2'b10, then 2'b01.
- R9: Retiring a pointer that matches no live chunk changes nothing. An allocation of size 0 records no chunk and does not touch table_full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | A transfer is on the bus this cycle |
| bus_addr | input | AW | Transfer start address |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_size | input | 2 | Transfer is 2^bus_size bytes |
| bus_app | input | 1 | Transfer issued by the monitored application |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | AW | Register write data |
| viol_flag | output | 1 | Latched violation, exception request |
| viol_addr | output | AW | Address of the captured violation |
| viol_cause | output | 2 | Cause of the captured violation |
| table_full | output | 1 | An allocation found no slot |

## Verification
Two things can meet in one cycle: the software clear of a latched violation and the arrival of a fresh offending transfer. The bench drives both in the same cycle on top of a flag that is already set. It then expects the flag to stay high with the new address and cause. A clear on its own must drop the flag, and an offending transfer on its own must leave the old capture in place. Freeing and reallocating one slot is also checked, to show that an old address falls back to the static-range rule and no longer counts as a use after free.

// File: rtl/zone_guard_pkg.sv
package zone_guard_pkg;
  typedef enum logic [1:0] {
    CAUSE_RO  = 2'b00,
    CAUSE_OOS = 2'b01,
    CAUSE_OOB = 2'b10,
    CAUSE_UAF = 2'b11
  } cause_e;

  localparam logic [2:0] OFS_RO_LO  = 3'd0;
  localparam logic [2:0] OFS_RO_HI  = 3'd1;
  localparam logic [2:0] OFS_SEC_LO = 3'd2;
  localparam logic [2:0] OFS_SEC_HI = 3'd3;
  localparam logic [2:0] OFS_A_PTR  = 3'd4;
  localparam logic [2:0] OFS_A_SIZE = 3'd5;
  localparam logic [2:0] OFS_FREE   = 3'd6;
  localparam logic [2:0] OFS_CLEAR  = 3'd7;
endpackage

// File: rtl/zg_cfg_regs.sv
module zg_cfg_regs
  import zone_guard_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] ro_lo,
  output logic [AW-1:0] ro_hi,
  output logic [AW-1:0] sec_lo,
  output logic [AW-1:0] sec_hi,
  output logic          alloc_req,
  output logic [AW-1:0] alloc_base,
  output logic [AW-1:0] alloc_size,
  output logic          free_req,
  output logic [AW-1:0] free_ptr,
  output logic          clr_viol,
  output logic          clr_full
);
  logic [AW-1:0] ro_lo_q, ro_hi_q, sec_lo_q, sec_hi_q, ptr_q;
  logic          en_ro_lo, en_ro_hi, en_sec_lo, en_sec_hi, en_ptr;

  always_comb begin
    en_ro_lo  = cfg_we && (cfg_addr == OFS_RO_LO);
    en_ro_hi  = cfg_we && (cfg_addr == OFS_RO_HI);
    en_sec_lo = cfg_we && (cfg_addr == OFS_SEC_LO);
    en_sec_hi = cfg_we && (cfg_addr == OFS_SEC_HI);
    en_ptr    = cfg_we && (cfg_addr == OFS_A_PTR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ro_lo_q  <= '0;
      ro_hi_q  <= '0;
      sec_lo_q <= '0;
      sec_hi_q <= '0;
      ptr_q    <= '0;
    end else begin
      if (en_ro_lo)  ro_lo_q  <= cfg_wdata;
      if (en_ro_hi)  ro_hi_q  <= cfg_wdata;
      if (en_sec_lo) sec_lo_q <= cfg_wdata;
      if (en_sec_hi) sec_hi_q <= cfg_wdata;
      if (en_ptr)    ptr_q    <= cfg_wdata;
    end
  end

  always_comb begin
    ro_lo      = ro_lo_q;
    ro_hi      = ro_hi_q;
    sec_lo     = sec_lo_q;
    sec_hi     = sec_hi_q;
    alloc_base = ptr_q;
    alloc_size = cfg_wdata;
    alloc_req  = cfg_we && (cfg_addr == OFS_A_SIZE) && (cfg_wdata != '0);
    free_ptr   = cfg_wdata;
    free_req   = cfg_we && (cfg_addr == OFS_FREE);
    clr_viol   = cfg_we && (cfg_addr == OFS_CLEAR) && cfg_wdata[0];
    clr_full   = cfg_we && (cfg_addr == OFS_CLEAR) && cfg_wdata[1];
  end
endmodule

// File: rtl/zg_chunk_table.sv
module zg_chunk_table #(
  parameter int unsigned AW    = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_req,
  input  logic [AW-1:0]    alloc_base,
  input  logic [AW-1:0]    alloc_size,
  input  logic             free_req,
  input  logic [AW-1:0]    free_ptr,
  input  logic             clr_full,
  input  logic [AW-1:0]    acc_start,
  input  logic [AW-1:0]    acc_end,
  output logic [DEPTH-1:0] live_start,
  output logic [DEPTH-1:0] live_fit,
  output logic [DEPTH-1:0] dead_start,
  output logic             full_err
);
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] valid_q, freed_q;
  logic [AW-1:0]    base_q [DEPTH];
  logic [AW-1:0]    last_q [DEPTH];
  logic [DEPTH-1:0] slot_wr, free_hit;
  logic             empty_found, dead_found, full_q, full_d;
  logic [IW-1:0]    empty_idx, dead_idx;

  always_comb begin
    empty_found = 1'b0;
    dead_found  = 1'b0;
    empty_idx   = '0;
    dead_idx    = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!valid_q[i] && !empty_found) begin
        empty_found = 1'b1;
        empty_idx   = IW'(i);
      end
      if (valid_q[i] && freed_q[i] && !dead_found) begin
        dead_found = 1'b1;
        dead_idx   = IW'(i);
      end
    end
    slot_wr = '0;
    if (alloc_req && empty_found)     slot_wr[empty_idx] = 1'b1;
    else if (alloc_req && dead_found) slot_wr[dead_idx]  = 1'b1;
  end

  always_comb begin
    full_d = clr_full ? 1'b0 : full_q;
    if (alloc_req && !empty_found && !dead_found) full_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  assign full_err = full_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic in_lo, in_hi;
    assign free_hit[g] = free_req && valid_q[g] && !freed_q[g] && (base_q[g] == free_ptr);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
        freed_q[g] <= 1'b0;
        base_q[g]  <= '0;
        last_q[g]  <= '0;
      end else if (slot_wr[g]) begin
        valid_q[g] <= 1'b1;
        freed_q[g] <= 1'b0;
        base_q[g]  <= alloc_base;
        last_q[g]  <= alloc_base + alloc_size - AW'(1);
      end else if (free_hit[g]) begin
        freed_q[g] <= 1'b1;
      end
    end

    always_comb begin
      in_lo          = (acc_start >= base_q[g]);
      in_hi          = (acc_start <= last_q[g]);
      live_start[g]  = valid_q[g] && !freed_q[g] && in_lo && in_hi;
      live_fit[g]    = live_start[g] && (acc_end <= last_q[g]);
      dead_start[g]  = valid_q[g] && freed_q[g] && in_lo && in_hi;
    end

    // R4: a retired entry keeps its bounds until an allocation reuses it
    a_r4_freed_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (freed_q[g] && !slot_wr[g]) |=> ($stable(base_q[g]) && $stable(last_q[g]) && freed_q[g]));
  end

  // R5: an allocation with no usable slot sets the full status
  a_r5_full_set: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && (&valid_q) && !(|freed_q)) |=> full_err);
endmodule

// File: rtl/zg_rule_check.sv
module zg_rule_check
  import zone_guard_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic             bus_write,
  input  logic             bus_app,
  input  logic [AW-1:0]    acc_start,
  input  logic [AW-1:0]    acc_end,
  input  logic [AW-1:0]    ro_lo,
  input  logic [AW-1:0]    ro_hi,
  input  logic [AW-1:0]    sec_lo,
  input  logic [AW-1:0]    sec_hi,
  input  logic [DEPTH-1:0] live_start,
  input  logic [DEPTH-1:0] live_fit,
  input  logic [DEPTH-1:0] dead_start,
  output logic             hit,
  output cause_e           cause
);
  logic ro_bad, uaf_bad, oob_bad, oos_bad, in_sec, any_live;

  always_comb begin
    any_live = |live_start;
    in_sec   = (acc_start >= sec_lo) && (acc_end <= sec_hi);
    ro_bad   = bus_write && (acc_start >= ro_lo) && (acc_start <= ro_hi);
    uaf_bad  = (|dead_start) && !any_live;
    oob_bad  = |(live_start & ~live_fit);
    oos_bad  = bus_write && bus_app && !in_sec && !any_live;
    hit      = ro_bad || uaf_bad || oob_bad || oos_bad;
    if (ro_bad)       cause = CAUSE_RO;
    else if (uaf_bad) cause = CAUSE_UAF;
    else if (oob_bad) cause = CAUSE_OOB;
    else              cause = CAUSE_OOS;
  end
endmodule

// File: rtl/zone_guard.sv
module zone_guard
  import zone_guard_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_write,
  input  logic [1:0]    bus_size,
  input  logic          bus_app,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [AW-1:0] cfg_wdata,
  output logic          viol_flag,
  output logic [AW-1:0] viol_addr,
  output logic [1:0]    viol_cause,
  output logic          table_full
);
  logic [AW-1:0]    ro_lo, ro_hi, sec_lo, sec_hi, alloc_base, alloc_size, free_ptr;
  logic             alloc_req, free_req, clr_viol, clr_full;
  logic [AW-1:0]    acc_end;
  logic [DEPTH-1:0] live_start, live_fit, dead_start;
  logic             rule_hit, capture;
  cause_e           rule_cause;
  logic             flag_q, flag_d;
  logic [AW-1:0]    addr_q;
  logic [1:0]       cause_q;

  assign acc_end = bus_addr + ((AW'(1) << bus_size) - AW'(1));

  zg_cfg_regs #(.AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .ro_lo(ro_lo), .ro_hi(ro_hi), .sec_lo(sec_lo), .sec_hi(sec_hi),
    .alloc_req(alloc_req), .alloc_base(alloc_base), .alloc_size(alloc_size),
    .free_req(free_req), .free_ptr(free_ptr), .clr_viol(clr_viol), .clr_full(clr_full)
  );

  zg_chunk_table #(.AW(AW), .DEPTH(DEPTH)) u_tab (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_base(alloc_base),
    .alloc_size(alloc_size), .free_req(free_req), .free_ptr(free_ptr), .clr_full(clr_full),
    .acc_start(bus_addr), .acc_end(acc_end), .live_start(live_start), .live_fit(live_fit),
    .dead_start(dead_start), .full_err(table_full)
  );

  zg_rule_check #(.AW(AW), .DEPTH(DEPTH)) u_rule (
    .bus_write(bus_write), .bus_app(bus_app), .acc_start(bus_addr), .acc_end(acc_end),
    .ro_lo(ro_lo), .ro_hi(ro_hi), .sec_lo(sec_lo), .sec_hi(sec_hi),
    .live_start(live_start), .live_fit(live_fit), .dead_start(dead_start),
    .hit(rule_hit), .cause(rule_cause)
  );

  always_comb begin
    capture = bus_valid && rule_hit && (!flag_q || clr_viol);
    flag_d  = flag_q;
    if (clr_viol) flag_d = 1'b0;
    if (capture)  flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      addr_q  <= '0;
      cause_q <= 2'b00;
    end else begin
      flag_q <= flag_d;
      if (capture) begin
        addr_q  <= bus_addr;
        cause_q <= rule_cause;
      end
    end
  end

  assign viol_flag  = flag_q;
  assign viol_addr  = addr_q;
  assign viol_cause = cause_q;

  // R6: a latched violation holds its capture until cleared
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_flag && !(cfg_we && cfg_addr == OFS_CLEAR && cfg_wdata[0]))
      |=> (viol_flag && $stable(viol_addr) && $stable(viol_cause)));

  // R6: the flag only rises after a bus transfer
  a_r6_needs_bus: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(viol_flag) |-> $past(bus_valid));

  // R1: a write into the read-only range is captured with cause 00
  a_r1_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr >= ro_lo && bus_addr <= ro_hi && !viol_flag)
      |=> (viol_flag && viol_cause == 2'b00 && viol_addr == $past(bus_addr)));

  // R7: a clear coinciding with a new violation keeps the flag set
  a_r7_clear_race: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_viol && bus_valid && rule_hit) |=> viol_flag);
endmodule

// File: tb/zone_guard_tb_top.sv
module zone_guard_tb_top;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_valid, bus_write, bus_app;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_size;
  logic          cfg_we;
  logic [2:0]    cfg_addr;
  logic [AW-1:0] cfg_wdata;
  logic          viol_flag, table_full;
  logic [AW-1:0] viol_addr;
  logic [1:0]    viol_cause;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  zone_guard #(.AW(AW), .DEPTH(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_write(bus_write), .bus_size(bus_size), .bus_app(bus_app),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .viol_flag(viol_flag), .viol_addr(viol_addr), .viol_cause(viol_cause),
    .table_full(table_full)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    bus_valid = 0; bus_write = 0; bus_app = 0; bus_addr = '0; bus_size = 2'd0;
    cfg_we = 0; cfg_addr = 3'd0; cfg_wdata = '0;
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic bus_op(input logic [31:0] a, input logic wr, input logic [1:0] sz, input logic app);
    @(negedge clk);
    bus_valid = 1; bus_addr = a; bus_write = wr; bus_size = sz; bus_app = app;
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic alloc(input logic [31:0] p, input logic [31:0] sz);
    reg_wr(3'd4, p);
    reg_wr(3'd5, sz);
  endtask

  task automatic clear_viol();
    reg_wr(3'd7, 32'h1);
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    reg_wr(3'd0, 32'h1000); reg_wr(3'd1, 32'h1FFF);
    reg_wr(3'd2, 32'h2000); reg_wr(3'd3, 32'h2FFF);
  endtask

  task automatic t_reset_state();
    check("R6 reset flag", {31'd0, viol_flag}, 32'd0);
    check("R6 reset addr", viol_addr, 32'd0);
    check("R5 reset full", {31'd0, table_full}, 32'd0);
  endtask

  task automatic t_r1_readonly();
    bus_op(32'h1004, 0, 2'd2, 1);
    check("R1 read ignored", {31'd0, viol_flag}, 32'd0);
    bus_op(32'h1004, 1, 2'd2, 0);
    check("R1 flag", {31'd0, viol_flag}, 32'd1);
    check("R1 cause", {30'd0, viol_cause}, 32'd0);
    check("R1 addr", viol_addr, 32'h1004);
    clear_viol();
    check("R6 clear", {31'd0, viol_flag}, 32'd0);
  endtask

  task automatic t_r2_section();
    bus_op(32'h2FFC, 1, 2'd2, 1);
    check("R2 inside ok", {31'd0, viol_flag}, 32'd0);
    bus_op(32'h5000, 1, 2'd2, 0);
    check("R2 non-app ignored", {31'd0, viol_flag}, 32'd0);
    bus_op(32'h5000, 0, 2'd2, 1);
    check("R2 app read ignored", {31'd0, viol_flag}, 32'd0);
    bus_op(32'h2FFE, 1, 2'd2, 1);
    check("R2 straddle flag", {31'd0, viol_flag}, 32'd1);
    check("R2 cause", {30'd0, viol_cause}, 32'd1);
    check("R2 addr", viol_addr, 32'h2FFE);
    clear_viol();
  endtask

  task automatic t_r3_chunk();
    alloc(32'h8000, 32'h20);
    bus_op(32'h801C, 1, 2'd2, 1);
    check("R3 inside chunk ok", {31'd0, viol_flag}, 32'd0);
    bus_op(32'h801E, 1, 2'd2, 1);
    check("R3 oob flag", {31'd0, viol_flag}, 32'd1);
    check("R3 R8 oob cause over oos", {30'd0, viol_cause}, 32'd2);
    check("R3 addr", viol_addr, 32'h801E);
    clear_viol();
  endtask

  task automatic t_r4_free();
    reg_wr(3'd6, 32'h8000);
    bus_op(32'h8004, 0, 2'd0, 0);
    check("R4 read after free", {31'd0, viol_flag}, 32'd1);
    check("R4 cause", {30'd0, viol_cause}, 32'd3);
    clear_viol();
    alloc(32'h9000, 32'h10);
    bus_op(32'h8008, 1, 2'd2, 1);
    check("R8 uaf over oos", {30'd0, viol_cause}, 32'd3);
    check("R4 still retired", {31'd0, viol_flag}, 32'd1);
    clear_viol();
  endtask

  task automatic t_r6_sticky();
    bus_op(32'h1000, 1, 2'd0, 0);
    bus_op(32'h5000, 1, 2'd0, 1);
    check("R6 sticky addr", viol_addr, 32'h1000);
    check("R6 sticky cause", {30'd0, viol_cause}, 32'd0);
    check("R6 sticky flag", {31'd0, viol_flag}, 32'd1);
  endtask

  task automatic t_r7_race();
    @(negedge clk);
    cfg_we = 1; cfg_addr = 3'd7; cfg_wdata = 32'h1;
    bus_valid = 1; bus_addr = 32'h1010; bus_write = 1; bus_size = 2'd0; bus_app = 0;
    @(negedge clk);
    cfg_we = 0; bus_valid = 0;
    check("R7 flag kept", {31'd0, viol_flag}, 32'd1);
    check("R7 new addr", viol_addr, 32'h1010);
    clear_viol();
    check("R7 plain clear", {31'd0, viol_flag}, 32'd0);
  endtask

  task automatic t_r5_full();
    do_reset();
    for (int i = 0; i < 8; i++) alloc(32'hA000 + 32'(i) * 32'h100, 32'h10);
    check("R5 eight fit", {31'd0, table_full}, 32'd0);
    alloc(32'hAF00, 32'h10);
    check("R5 full set", {31'd0, table_full}, 32'd1);
    check("R5 no violation", {31'd0, viol_flag}, 32'd0);
    reg_wr(3'd7, 32'h2);
    check("R5 full cleared", {31'd0, table_full}, 32'd0);
    reg_wr(3'd6, 32'hA300);
    alloc(32'hB000, 32'h10);
    check("R5 reuse no full", {31'd0, table_full}, 32'd0);
    bus_op(32'hB004, 1, 2'd2, 1);
    check("R5 reused slot live", {31'd0, viol_flag}, 32'd0);
    bus_op(32'hA304, 1, 2'd2, 1);
    check("R4 slot reused gives oos", {30'd0, viol_cause}, 32'd1);
    clear_viol();
  endtask

  task automatic t_r9_noops();
    reg_wr(3'd6, 32'h7777);
    bus_op(32'hA004, 1, 2'd2, 1);
    check("R9 unknown free no effect", {31'd0, viol_flag}, 32'd0);
    alloc(32'hC000, 32'h0);
    check("R9 zero size no full", {31'd0, table_full}, 32'd0);
    bus_op(32'hC000, 1, 2'd0, 1);
    check("R9 zero size no chunk", {30'd0, viol_cause}, 32'd1);
    check("R9 flag", {31'd0, viol_flag}, 32'd1);
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_r1_readonly();
    t_r2_section();
    t_r3_chunk();
    t_r4_free();
    t_r6_sticky();
    t_r7_race();
    t_r5_full();
    t_r9_noops();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule